// File: doc/BRIEF.md
# Keyed I/O-controller configuration register file

This block holds the setup of a multi-function I/O controller that carries one parallel port and two serial ports. The host reaches it through a two-address port pair. Address 0 is the index/key port and address 1 is the data port. While the block is locked, it ignores every access except one specific key byte written to the index port. That key unlocks configuration mode.

Once the block is unlocked, a byte written to the index port selects a register. Data-port reads and writes then reach the selected register. A second key byte written to the index port locks the block again.

The stored registers drive decoded outputs for each function:
- an 8-bit base-address field,
- an IRQ select,
- a DMA select for the parallel port,
- a registered "active" flag, which is high only when the function's power bit is set and its base field is nonzero.

The functional peripherals are not part of the block.

Top module: `sio_cfg_regs`

## Requirements
- R1: While locked, writing 0x55 to the index port (bus_addr=0) enters configuration mode from the next cycle and clears the index to 0x00.
- R2: While locked, data-port writes change no register, every other index-port value is ignored, and reads on either address return 0x00.
- R3: In configuration mode, writing 0xAA to the index port leaves the mode, so 0xAA never becomes an index. Any other index-port value, including 0x55, becomes the index, and reading the index port returns the current index.
- R4: In configuration mode, implemented registers (0x01, 0x02, 0x23 to 0x28) store all 8 written bits and read back their current value on the data port. All other indices read 0x00 and ignore writes.
- R5: Registers 0x23, 0x24 and 0x25 drive pp_base, sp1_base and sp2_base directly. Each holds I/O address bits [9:2].
- R6: pp_dma is register 0x26 bits [3:0]. pp_irq is 0x27 bits [3:0]. sp1_irq is 0x28 bits [7:4] and sp2_irq is 0x28 bits [3:0].
- R7: The power bits are register 0x01 bit 2 (parallel), register 0x02 bit 3 (serial 1) and register 0x02 bit 7 (serial 2).
- R8: Each active output equals its power bit AND (base != 0), as seen one clock earlier. A write therefore shows on the active outputs one clock after it shows on the register outputs.
- R9: Reset leaves the block locked, with the index and all implemented registers at 0x00, so every active output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = index/key port, 1 = data port |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read of the addressed port |
| cfg_mode | output | 1 | Configuration mode is open |
| pp_base | output | 8 | Parallel port base, address bits [9:2] |
| sp1_base | output | 8 | Serial 1 base, address bits [9:2] |
| sp2_base | output | 8 | Serial 2 base, address bits [9:2] |
| pp_irq | output | 4 | Parallel port IRQ select |
| sp1_irq | output | 4 | Serial 1 IRQ select |
| sp2_irq | output | 4 | Serial 2 IRQ select |
| pp_dma | output | 4 | Parallel port DMA select |
| pp_active | output | 1 | Parallel port powered with nonzero base |
| sp1_active | output | 1 | Serial 1 powered with nonzero base |
| sp2_active | output | 1 | Serial 2 powered with nonzero base |

## Verification
The active flags lag the register writes by one clock. Because of that lag, the delayed active update from one write lands in the same cycle as the next bus operation. That next operation can be a relocking key write, or a data write that is about to be ignored.

The bench provokes this overlap in two ways:
- a directed sequence writes a power bit and locks the block on the very next cycle;
- random operation streams run back-to-back with no idle cycles.

Each active flag is judged against a bench model evaluated on the register image from before the latest edge. The register outputs and reads are judged against the image from after that edge.

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs #(
  parameter logic [7:0] ENTER_KEY = 8'h55,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       cfg_mode,
  output logic [7:0] pp_base,
  output logic [7:0] sp1_base,
  output logic [7:0] sp2_base,
  output logic [3:0] pp_irq,
  output logic [3:0] sp1_irq,
  output logic [3:0] sp2_irq,
  output logic [3:0] pp_dma,
  output logic       pp_active,
  output logic       sp1_active,
  output logic       sp2_active
);

  logic [7:0] idx;
  logic [7:0] r_pwr_pp, r_pwr_sp, r_dma, r_irq_pp, r_irq_sp;
  logic       key_wr, dat_wr;

  assign key_wr = wr_en && !bus_addr;
  assign dat_wr = wr_en && bus_addr && cfg_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      idx      <= 8'h00;
    end else if (key_wr) begin
      if (!cfg_mode) begin
        if (wr_data == ENTER_KEY) begin
          cfg_mode <= 1'b1;
          idx      <= 8'h00;
        end
      end else if (wr_data == EXIT_KEY) begin
        cfg_mode <= 1'b0;
      end else begin
        idx <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_pwr_pp <= 8'h00;
      r_pwr_sp <= 8'h00;
      pp_base  <= 8'h00;
      sp1_base <= 8'h00;
      sp2_base <= 8'h00;
      r_dma    <= 8'h00;
      r_irq_pp <= 8'h00;
      r_irq_sp <= 8'h00;
    end else if (dat_wr) begin
      case (idx)
        8'h01: r_pwr_pp <= wr_data;
        8'h02: r_pwr_sp <= wr_data;
        8'h23: pp_base  <= wr_data;
        8'h24: sp1_base <= wr_data;
        8'h25: sp2_base <= wr_data;
        8'h26: r_dma    <= wr_data;
        8'h27: r_irq_pp <= wr_data;
        8'h28: r_irq_sp <= wr_data;
        default: ;
      endcase
    end
  end

  logic [7:0] reg_rd;
  always_comb begin
    case (idx)
      8'h01:   reg_rd = r_pwr_pp;
      8'h02:   reg_rd = r_pwr_sp;
      8'h23:   reg_rd = pp_base;
      8'h24:   reg_rd = sp1_base;
      8'h25:   reg_rd = sp2_base;
      8'h26:   reg_rd = r_dma;
      8'h27:   reg_rd = r_irq_pp;
      8'h28:   reg_rd = r_irq_sp;
      default: reg_rd = 8'h00;
    endcase
  end

  assign rd_data = !cfg_mode ? 8'h00 : (bus_addr ? reg_rd : idx);

  assign pp_dma  = r_dma[3:0];
  assign pp_irq  = r_irq_pp[3:0];
  assign sp1_irq = r_irq_sp[7:4];
  assign sp2_irq = r_irq_sp[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_active  <= 1'b0;
      sp1_active <= 1'b0;
      sp2_active <= 1'b0;
    end else begin
      pp_active  <= r_pwr_pp[2] && (pp_base  != 8'h00);
      sp1_active <= r_pwr_sp[3] && (sp1_base != 8'h00);
      sp2_active <= r_pwr_sp[7] && (sp2_base != 8'h00);
    end
  end

  p_enter_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && key_wr && wr_data == ENTER_KEY) |=> cfg_mode);

  p_exit_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && key_wr && wr_data == EXIT_KEY) |=> !cfg_mode);

  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && wr_en && bus_addr) |=>
      ($stable(pp_base) && $stable(sp1_base) && $stable(sp2_base) &&
       $stable(pp_dma) && $stable(pp_irq) && $stable(sp1_irq) && $stable(sp2_irq)));

  p_locked_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> rd_data == 8'h00);

  p_pp_active_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pp_active |-> $past(pp_base) != 8'h00);

  p_sp1_active_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp1_active |-> $past(sp1_base) != 8'h00);

  p_sp2_active_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp2_active |-> $past(sp2_base) != 8'h00);

endmodule

// File: tb/sio_cfg_regs_tb.sv
module sio_cfg_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, pp_base, sp1_base, sp2_base;
  logic [3:0] pp_irq, sp1_irq, sp2_irq, pp_dma;
  logic cfg_mode, pp_active, sp1_active, sp2_active;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_reg [256];
  logic       m_mode;
  logic [7:0] m_idx;
  logic [2:0] act_exp;

  always #5 clk = ~clk;

  sio_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_mode(cfg_mode), .pp_base(pp_base), .sp1_base(sp1_base),
    .sp2_base(sp2_base), .pp_irq(pp_irq), .sp1_irq(sp1_irq), .sp2_irq(sp2_irq),
    .pp_dma(pp_dma), .pp_active(pp_active), .sp1_active(sp1_active), .sp2_active(sp2_active)
  );

  function automatic bit impl(input logic [7:0] i);
    return (i == 8'h01) || (i == 8'h02) || (i >= 8'h23 && i <= 8'h28);
  endfunction

  function automatic logic [7:0] exp_rd(input logic a);
    if (!m_mode) return 8'h00;
    if (!a) return m_idx;
    return impl(m_idx) ? m_reg[m_idx] : 8'h00;
  endfunction

  function automatic logic [2:0] exp_act();
    return {m_reg[8'h02][7] && (m_reg[8'h25] != 0),
            m_reg[8'h02][3] && (m_reg[8'h24] != 0),
            m_reg[8'h01][2] && (m_reg[8'h23] != 0)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R1/R3 mode", {31'd0, cfg_mode}, {31'd0, m_mode});
    chk("R5 bases", {8'd0, pp_base, sp1_base, sp2_base},
        {8'd0, m_reg[8'h23], m_reg[8'h24], m_reg[8'h25]});
    chk("R6 irq/dma", {16'd0, pp_irq, sp1_irq, sp2_irq, pp_dma},
        {16'd0, m_reg[8'h27][3:0], m_reg[8'h28][7:4], m_reg[8'h28][3:0], m_reg[8'h26][3:0]});
    chk("R7/R8 active", {29'd0, sp2_active, sp1_active, pp_active}, {29'd0, act_exp});
  endtask

  task automatic step(input logic a, input logic we, input logic [7:0] d);
    @(negedge clk);
    check_outs();
    bus_addr = a; wr_en = we; wr_data = d;
    #1;
    chk(m_mode ? "R4/R3 read" : "R2 locked read", {24'd0, rd_data}, {24'd0, exp_rd(a)});
    @(posedge clk);
    act_exp = exp_act();
    if (we) begin
      if (!a) begin
        if (!m_mode) begin
          if (d == 8'h55) begin m_mode = 1'b1; m_idx = 8'h00; end
        end else if (d == 8'hAA) m_mode = 1'b0;
        else m_idx = d;
      end else if (m_mode && impl(m_idx)) m_reg[m_idx] = d;
    end
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    step(1'b0, 1'b1, i);
    step(1'b1, 1'b1, d);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pick [8];
    pick = '{8'h01, 8'h02, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28};
    for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
    m_mode = 1'b0; m_idx = 8'h00; act_exp = 3'b000;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9 reset state
    @(negedge clk);
    chk("R9 reset mode", {31'd0, cfg_mode}, 32'd0);
    chk("R9 reset bases", {8'd0, pp_base, sp1_base, sp2_base}, 32'd0);
    chk("R9 reset active", {29'd0, sp2_active, sp1_active, pp_active}, 32'd0);
    // R2 locked: data write and wrong key ignored
    step(1'b1, 1'b1, 8'h12);
    step(1'b0, 1'b1, 8'h23);
    step(1'b1, 1'b1, 8'h40);
    step(1'b0, 1'b0, 8'h00);
    // R1 enter, index cleared
    step(1'b0, 1'b1, 8'h55);
    step(1'b0, 1'b0, 8'h00);
    // R5/R7/R8 parallel port powered
    wr_reg(8'h23, 8'hDE);
    wr_reg(8'h01, 8'h04);
    // R3: power serial 1 then relock right after (overlap with active update)
    wr_reg(8'h24, 8'hFE);
    wr_reg(8'h02, 8'h08);
    step(1'b0, 1'b1, 8'hAA);
    step(1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    // R3: 0x55 inside mode becomes index; R4 unimplemented index
    step(1'b0, 1'b1, 8'h55);
    step(1'b0, 1'b1, 8'h55);
    step(1'b1, 1'b1, 8'h77);
    step(1'b1, 1'b0, 8'h00);
    // R6 nibble RMW on 0x28 and DMA upper bits kept
    wr_reg(8'h28, 8'h5A);
    step(1'b1, 1'b1, 8'h3A);
    wr_reg(8'h26, 8'hF3);
    step(1'b1, 1'b0, 8'h00);
    // R8 base to zero drops active
    wr_reg(8'h23, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      if (r < 6) step(1'b0, 1'b1, 8'h55);
      else if (r < 10) step(1'b0, 1'b1, 8'hAA);
      else if (r < 35) step(1'b0, 1'b1, ($urandom_range(0, 3) == 0) ? 8'($urandom) : pick[$urandom_range(0, 7)]);
      else if (r < 75) step(1'b1, 1'b1, 8'($urandom));
      else step(1'($urandom), 1'b0, 8'($urandom));
    end
    step(1'b0, 1'b0, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule